// File: doc/BRIEF.md
# Timer/Counter Channel with Overflow Toggle Output

This block is one timer/counter channel for a small microcontroller subsystem. It keeps a 16-bit count as a high byte and a low byte. It can advance on ticks of an internal time base or on falling edges of an external pin. The internal time base is a machine cycle of either twelve or four system clocks. The external pin is sampled once per machine cycle. A high sample followed by a low sample counts as one falling edge, and that edge is added at the next machine-cycle boundary.

Three counting modes are supported:
- a 13-bit counter;
- a full 16-bit counter;
- an 8-bit counter in the low byte that reloads itself from the high byte.

A fourth mode code freezes the count. Each overflow sets a sticky flag. Software clears the flag, or the interrupt acknowledge clears it. In timer operation, an optional output pin inverts on every overflow. Software can write either count byte at any time.

Top module: `tmr_chan`

## Requirements
- R1: After reset, both count bytes are 0x00, the overflow flag is 0 and the toggle output is 1.
- R2: In timer operation (`src_ext_i`=0), the count advances once per machine cycle. A machine cycle is 12 clocks when `fast_i`=0 and 4 clocks when `fast_i`=1.
- R3: The channel advances only while `run_i`=1 and either `gate_en_i`=0 or `ext_gate_i`=1. Otherwise the count holds in both timer and counter operation.
- R4: In counter operation (`src_ext_i`=1), `cnt_pin_i` is sampled once per machine cycle. A 1 sample followed by a 0 sample in the next machine cycle is one falling edge. Each such edge advances the count by exactly one, at the next machine-cycle boundary.
- R5: Mode code 2'b00 counts the 13-bit value {high byte, low byte bits 4:0}. Low byte bits 7:5 keep their value. An overflow occurs on the step from 0x1FFF to 0x0000.
- R6: Mode code 2'b01 counts the full 16-bit value {high, low}, and overflows on the step from 0xFFFF to 0x0000.
- R7: Mode code 2'b10 counts in the low byte only. On the step from 0xFF the low byte takes the high byte's value and an overflow occurs. The high byte never changes in this mode except by a write.
- R8: Mode code 2'b11 holds both count bytes.
- R9: An overflow sets the flag in the same clock edge on which the count wraps. `flag_clr_i` or `int_ack_i` clears the flag on a later edge. A set on the same edge takes priority over a clear.
- R10: When `tog_en_i`=1 in timer operation, the toggle output inverts on every overflow. It does not change when `tog_en_i`=0 or in counter operation.
- R11: `hi_wr_i` and `lo_wr_i` load `wr_data_i` into the high or low byte. A cycle with any write performs no increment and no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run enable |
| gate_en_i | input | 1 | Makes counting depend on `ext_gate_i` |
| ext_gate_i | input | 1 | External gate level |
| src_ext_i | input | 1 | 0 selects time-base ticks, 1 selects external falling edges |
| mode_i | input | 2 | Counting mode code |
| fast_i | input | 1 | 1 selects the 4-clock machine cycle, 0 the 12-clock one |
| tog_en_i | input | 1 | Enables the overflow toggle output |
| cnt_pin_i | input | 1 | External count pin |
| flag_clr_i | input | 1 | Software clear of the overflow flag |
| int_ack_i | input | 1 | Interrupt acknowledge, also clears the flag |
| hi_wr_i | input | 1 | Write strobe for the high byte |
| lo_wr_i | input | 1 | Write strobe for the low byte |
| wr_data_i | input | 8 | Write data for either byte |
| hi_o | output | 8 | High count byte |
| lo_o | output | 8 | Low count byte |
| ovf_flag_o | output | 1 | Sticky overflow flag / interrupt request |
| tog_o | output | 1 | Overflow toggle output |

## Verification
Two pairs of events can fall on the same clock edge: a byte write with a pending increment, and an overflow with a flag clear.

For the first pair, the bench holds both write strobes on, with all ones as data, while the fast time base runs. The count must stay at 0xFFFF and the flag must stay 0 through many ticks. Once the strobes drop, the count must wrap within one machine cycle.

For the second pair, the bench holds `flag_clr_i` on while a wrap happens. It watches every clock edge and requires the flag to read 1 exactly on the edge where the count moves from 0xFFFF to 0x0000. After that the held clear must take the flag back to 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W  = 8;
    localparam int LOW13_W = 5;
    localparam int CNT13_W = BYTE_W + LOW13_W;
    localparam int CNT16_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        MODE_13     = 2'b00,
        MODE_16     = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_HOLD   = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_t;

    typedef struct packed {
        cnt_t nxt;
        logic ovf;
    } step_t;

    // One increment of the count in the given mode.
    function automatic step_t tmr_step(tmr_mode_e m, cnt_t c);
        step_t               r;
        logic [CNT13_W-1:0]  v13;
        logic [CNT16_W-1:0]  v16;
        r.nxt = c;
        r.ovf = 1'b0;
        v13   = {c.hi, c.lo[LOW13_W-1:0]};
        v16   = {c.hi, c.lo};
        unique case (m)
            MODE_13: begin
                r.ovf = &v13;
                v13   = v13 + CNT13_W'(1);
                r.nxt.hi = v13[CNT13_W-1:LOW13_W];
                r.nxt.lo[LOW13_W-1:0] = v13[LOW13_W-1:0];
            end
            MODE_16: begin
                r.ovf = &v16;
                v16   = v16 + CNT16_W'(1);
                r.nxt.hi = v16[CNT16_W-1:BYTE_W];
                r.nxt.lo = v16[BYTE_W-1:0];
            end
            MODE_RELOAD: begin
                r.ovf    = &c.lo;
                r.nxt.lo = r.ovf ? c.hi : c.lo + BYTE_W'(1);
            end
            default: begin
                r.ovf = 1'b0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fast_i,
    output logic tick_o
);
    localparam int PW = $clog2(SLOW_DIV);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim;

    assign lim    = fast_i ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
    assign tick_o = (pre_q >= lim);

    always_ff @(posedge clk) begin
        if (rst)         pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + PW'(1);
    end

    // R2
    pre_range_chk: assert property (@(posedge clk) disable iff (rst)
        pre_q <= PW'(SLOW_DIV - 1));

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic pin_i,
    output logic edge_o
);
    logic samp_q;
    logic pend_q;

    // Sampling and detection happen only on machine-cycle boundaries;
    // a detected fall is applied at the following boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (tick_i) begin
            samp_q <= pin_i;
            pend_q <= samp_q & ~pin_i;
        end
    end

    assign edge_o = tick_i & pend_q;

    // R4
    edge_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o);

endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_i,
    input  tmr_mode_e         mode_i,
    input  logic              hi_wr_i,
    input  logic              lo_wr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output cnt_t              cnt_o,
    output logic              ovf_o
);
    cnt_t  cnt_q;
    step_t step;
    logic  wr_any;

    assign wr_any = hi_wr_i | lo_wr_i;
    assign step   = tmr_step(mode_i, cnt_q);
    assign ovf_o  = inc_i & ~wr_any & step.ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_any) begin
            if (hi_wr_i) cnt_q.hi <= wr_data_i;
            if (lo_wr_i) cnt_q.lo <= wr_data_i;
        end else if (inc_i) begin
            cnt_q <= step.nxt;
        end
    end

    assign cnt_o = cnt_q;

    // R11
    hi_write_chk: assert property (@(posedge clk) disable iff (rst)
        hi_wr_i |=> cnt_o.hi == $past(wr_data_i));

    // R7
    reload_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_RELOAD && !hi_wr_i) |=> $stable(cnt_o.hi));

    // R8
    hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_HOLD && !hi_wr_i && !lo_wr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              gate_en_i,
    input  logic              ext_gate_i,
    input  logic              src_ext_i,
    input  logic [1:0]        mode_i,
    input  logic              fast_i,
    input  logic              tog_en_i,
    input  logic              cnt_pin_i,
    input  logic              flag_clr_i,
    input  logic              int_ack_i,
    input  logic              hi_wr_i,
    input  logic              lo_wr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [BYTE_W-1:0] hi_o,
    output logic [BYTE_W-1:0] lo_o,
    output logic              ovf_flag_o,
    output logic              tog_o
);
    logic tick;
    logic ext_edge;
    logic enable;
    logic inc;
    logic ovf;
    logic flag_q;
    logic tog_q;
    cnt_t cnt;

    tmr_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .fast_i (fast_i),
        .tick_o (tick)
    );

    tmr_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .pin_i  (cnt_pin_i),
        .edge_o (ext_edge)
    );

    assign enable = run_i & (~gate_en_i | ext_gate_i);
    assign inc    = enable & (src_ext_i ? ext_edge : tick);

    tmr_count u_cnt (
        .clk       (clk),
        .rst       (rst),
        .inc_i     (inc),
        .mode_i    (tmr_mode_e'(mode_i)),
        .hi_wr_i   (hi_wr_i),
        .lo_wr_i   (lo_wr_i),
        .wr_data_i (wr_data_i),
        .cnt_o     (cnt),
        .ovf_o     (ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            tog_q  <= 1'b1;
        end else begin
            if (ovf)                          flag_q <= 1'b1;
            else if (flag_clr_i || int_ack_i) flag_q <= 1'b0;
            if (ovf && tog_en_i && !src_ext_i) tog_q <= ~tog_q;
        end
    end

    assign hi_o       = cnt.hi;
    assign lo_o       = cnt.lo;
    assign ovf_flag_o = flag_q;
    assign tog_o      = tog_q;

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf_flag_o);

    // R10
    tog_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && tog_en_i && !src_ext_i) |=> tog_o != $past(tog_o));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !hi_wr_i && !lo_wr_i) |=> ({hi_o, lo_o} == $past({hi_o, lo_o})));

endmodule

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_i = 0, gate_en_i = 0, ext_gate_i = 0, src_ext_i = 0;
    logic [1:0] mode_i = 2'b01;
    logic       fast_i = 0, tog_en_i = 0, cnt_pin_i = 1;
    logic       flag_clr_i = 0, int_ack_i = 0, hi_wr_i = 0, lo_wr_i = 0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] hi_o, lo_o;
    logic       ovf_flag_o, tog_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    tmr_chan u_dut (
        .clk(clk), .rst(rst), .run_i(run_i), .gate_en_i(gate_en_i),
        .ext_gate_i(ext_gate_i), .src_ext_i(src_ext_i), .mode_i(mode_i),
        .fast_i(fast_i), .tog_en_i(tog_en_i), .cnt_pin_i(cnt_pin_i),
        .flag_clr_i(flag_clr_i), .int_ack_i(int_ack_i), .hi_wr_i(hi_wr_i),
        .lo_wr_i(lo_wr_i), .wr_data_i(wr_data_i), .hi_o(hi_o), .lo_o(lo_o),
        .ovf_flag_o(ovf_flag_o), .tog_o(tog_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int mdiv();
        return fast_i ? 4 : 12;
    endfunction

    task automatic load(input logic [7:0] h, input logic [7:0] l);
        hi_wr_i = 1; wr_data_i = h; clocks(1);
        hi_wr_i = 0; lo_wr_i = 1; wr_data_i = l; clocks(1);
        lo_wr_i = 0;
    endtask

    task automatic clear_flag();
        flag_clr_i = 1; clocks(1); flag_clr_i = 0;
    endtask

    task automatic run_mc(input int k);
        run_i = 1; clocks(k * mdiv()); run_i = 0;
    endtask

    task automatic pulse_pin(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_pin_i = 0; clocks(3 * mdiv());
            cnt_pin_i = 1; clocks(3 * mdiv());
        end
    endtask

    // Reference step: returns {ovf, value} for one increment.
    function automatic logic [16:0] ref_step(input int m, input logic [15:0] v);
        int h, l, x;
        h = int'(v[15:8]);
        l = int'(v[7:0]);
        case (m)
            0: begin
                x = h * 32 + (l % 32) + 1;
                return {x == 8192, 8'((x % 8192) / 32), 8'((l / 32) * 32 + (x % 32))};
            end
            1: begin
                x = int'(v) + 1;
                return {x == 65536, 16'(x % 65536)};
            end
            2: begin
                if (l == 255) return {1'b1, 8'(h), 8'(h)};
                return {1'b0, 8'(h), 8'(l + 1)};
            end
            default: return {1'b0, v};
        endcase
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v0;
        logic [16:0] s;
        int          novf;
        logic        t0;
        bit          seen;
        logic [15:0] starts [3];
        int          ks [3];
        starts[0] = 16'hFFFC; starts[1] = 16'hFF1E; starts[2] = 16'h12FE;
        ks[0] = 1; ks[1] = 3; ks[2] = 9;

        clocks(5);
        rst = 0;
        clocks(1);
        // R1
        check(hi_o == 0 && lo_o == 0, "R1 count after reset", {hi_o, lo_o}, 0);
        check(ovf_flag_o == 0 && tog_o == 1, "R1 flag/toggle after reset",
              {ovf_flag_o, tog_o}, 1);

        // R2 R5 R6 R7 R9 R10: sweep of modes, time bases, start values, lengths
        tog_en_i = 1;
        for (int m = 0; m < 3; m++) begin
            for (int f = 0; f < 2; f++) begin
                for (int si = 0; si < 3; si++) begin
                    for (int ki = 0; ki < 3; ki++) begin
                        mode_i = 2'(m); fast_i = f[0];
                        clocks(12);
                        load(starts[si][15:8], starts[si][7:0]);
                        clear_flag();
                        t0 = tog_o;
                        v = starts[si]; novf = 0;
                        for (int j = 0; j < ks[ki]; j++) begin
                            s = ref_step(m, v);
                            v = s[15:0];
                            novf += int'(s[16]);
                        end
                        run_mc(ks[ki]);
                        check({hi_o, lo_o} == v,
                              (m == 0) ? "R5 13-bit count" : (m == 1) ? "R6 16-bit count" : "R7 reload count",
                              {hi_o, lo_o}, v);
                        check(ovf_flag_o == (novf > 0), "R9 flag after sweep run",
                              ovf_flag_o, novf > 0);
                        check(tog_o == (t0 ^ novf[0]), "R10 toggle parity",
                              tog_o, t0 ^ novf[0]);
                    end
                end
            end
        end

        // R2: exact tick rate over a long window, both time bases
        mode_i = 2'b01;
        for (int f = 0; f < 2; f++) begin
            fast_i = f[0]; clocks(12);
            load(8'h00, 8'h00);
            run_i = 1; clocks(60); run_i = 0;
            check({hi_o, lo_o} == (f ? 15 : 5), "R2 ticks in 60 clocks",
                  {hi_o, lo_o}, f ? 15 : 5);
        end

        // R9: clear by flag_clr_i and by int_ack_i
        load(8'hFF, 8'hFF); run_mc(1);
        check(ovf_flag_o == 1, "R9 flag set", ovf_flag_o, 1);
        int_ack_i = 1; clocks(1); int_ack_i = 0;
        check(ovf_flag_o == 0, "R9 flag cleared by ack", ovf_flag_o, 0);
        load(8'hFF, 8'hFF); run_mc(1);
        clear_flag();
        check(ovf_flag_o == 0, "R9 flag cleared by software", ovf_flag_o, 0);

        // R9: set wins over a held clear on the wrap edge
        fast_i = 1; clocks(12);
        load(8'hFF, 8'hFF);
        flag_clr_i = 1; run_i = 1; seen = 0;
        v0 = {hi_o, lo_o};
        for (int i = 0; i < 4; i++) begin
            clocks(1);
            if (v0 == 16'hFFFF && {hi_o, lo_o} == 16'h0000) begin
                seen = 1;
                check(ovf_flag_o == 1, "R9 set beats clear", ovf_flag_o, 1);
            end
            v0 = {hi_o, lo_o};
        end
        run_i = 0; clocks(1);
        check(seen, "R9 wrap observed", seen, 1);
        flag_clr_i = 0;
        check(ovf_flag_o == 0, "R9 held clear after wrap", ovf_flag_o, 0);

        // R11: writes every cycle suppress increments and overflow
        load(8'h00, 8'h00);
        hi_wr_i = 1; lo_wr_i = 1; wr_data_i = 8'hFF; run_i = 1;
        seen = 0;
        for (int i = 0; i < 24; i++) begin
            clocks(1);
            if ({hi_o, lo_o} != 16'hFFFF || ovf_flag_o) seen = 1;
        end
        check(!seen, "R11 write priority", {hi_o, lo_o}, 16'hFFFF);
        hi_wr_i = 0; lo_wr_i = 0;
        clocks(4); run_i = 0;
        check(ovf_flag_o == 1, "R11 counting resumes after writes", ovf_flag_o, 1);
        clear_flag();

        // R3: gate
        load(8'h00, 8'h10);
        gate_en_i = 1; ext_gate_i = 0; run_mc(5);
        check({hi_o, lo_o} == 16'h0010, "R3 gated off", {hi_o, lo_o}, 16'h0010);
        ext_gate_i = 1; run_mc(5);
        check({hi_o, lo_o} == 16'h0015, "R3 gate open", {hi_o, lo_o}, 16'h0015);
        gate_en_i = 0; ext_gate_i = 0;

        // R8: hold mode
        mode_i = 2'b11; run_mc(7);
        check({hi_o, lo_o} == 16'h0015, "R8 hold mode", {hi_o, lo_o}, 16'h0015);
        mode_i = 2'b01;

        // R10: no toggle when disabled
        tog_en_i = 0; t0 = tog_o;
        load(8'hFF, 8'hFF); run_mc(1);
        check(tog_o == t0 && ovf_flag_o == 1, "R10 toggle disabled", tog_o, t0);
        clear_flag(); tog_en_i = 1;

        // R4: external edges, both time bases
        src_ext_i = 1;
        for (int f = 1; f >= 0; f--) begin
            fast_i = f[0]; cnt_pin_i = 1; clocks(12);
            load(8'h00, 8'h00);
            run_i = 1; clocks(3 * mdiv());
            pulse_pin(f ? 5 : 3);
            clocks(2 * mdiv());
            run_i = 0;
            check({hi_o, lo_o} == (f ? 5 : 3), "R4 falling edges counted",
                  {hi_o, lo_o}, f ? 5 : 3);
        end
        // R3: edges ignored while stopped
        pulse_pin(2);
        check({hi_o, lo_o} == 3, "R3 edges ignored when stopped", {hi_o, lo_o}, 3);
        // R10: counter-mode overflow leaves toggle alone
        fast_i = 1; clocks(12);
        load(8'hFF, 8'hFF); t0 = tog_o;
        run_i = 1; pulse_pin(1); clocks(8); run_i = 0;
        check({hi_o, lo_o} == 0 && ovf_flag_o == 1, "R4 edge wrap", {hi_o, lo_o, 7'd0, ovf_flag_o}, 1);
        check(tog_o == t0, "R10 no toggle in counter mode", tog_o, t0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule